// File: doc/BRIEF.md
# Timer and alarm interrupt controller

This block holds the two event flags of a clock/calendar device, one raised by the alarm comparator and one raised when the countdown timer expires. It also holds the two interrupt enables and the timer interrupt style bit. A host reads and writes all five bits as one control/status byte. The write rules let the host clear either flag without disturbing the other. The block drives an active-low, open-drain interrupt line. That line is modelled here as a pull-low enable: 1 means the pin is driven low, and 0 means the pin is released.

The timer part of the interrupt has two styles. In level style it follows the timer flag. In pulse style the line is pulled low for a short window that opens on the same clock edge as the flag. The window length depends on the timer's source clock and on the countdown value that was loaded. It is timed by counting one-cycle enables taken from an 8192 Hz reference. The alarm part is always a level.

Top module: `irqc_top`

## Requirements
- R1: After reset, the readback byte is 0x00 and `irq_pull` is 0.
- R2: The readback byte carries the style bit (1 = pulse) at bit 4, the alarm flag at bit 3, the timer flag at bit 2, the alarm enable at bit 1 and the timer enable at bit 0. Bits 7 to 5 always read 0. A write loads bits 4, 1 and 0 directly.
- R3: Writing 0 to bit 3 or bit 2 clears that flag. Writing 1 leaves the flag unchanged and never sets it.
- R4: An `alarm_hit` strobe sets the alarm flag and a `timer_done` strobe sets the timer flag. Each flag stays set until the host clears it. If a strobe and a clearing write land in the same cycle, the flag ends up set.
- R5: With both enables at 0, `irq_pull` stays 0 whatever the flags are.
- R6: Alarm flag and alarm enable both at 1 hold `irq_pull` at 1 continuously, in either style.
- R7: In level style, the timer part of the interrupt equals the timer flag gated by the timer enable.
- R8: In pulse style with the timer enable set, `irq_pull` rises in the same cycle the timer flag reads 1. It falls once the selected number of `tick_8k` enables has been counted, while the flag stays set.
- R9: Window lengths in reference ticks. `tmr_src` encodes 0 = 4096 Hz, 1 = 64 Hz, 2 = 1 Hz and 3 = 1/60 Hz. For source 0 the window is 1 tick when the loaded value is 1 and 2 ticks otherwise. For source 1 it is 64 ticks when the value is 1 and 128 ticks otherwise. For sources 2 and 3 it is 128 ticks.
- R10: A `timer_done` that arrives while a window is open restarts the full window count.
- R11: In pulse style with the timer enable at 0, a timer event leaves `irq_pull` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the control/status byte |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Control/status byte readback |
| alarm_hit | input | 1 | One-cycle alarm match strobe |
| timer_done | input | 1 | One-cycle countdown expiry strobe |
| tick_8k | input | 1 | One-cycle enable at 8192 Hz |
| tmr_src | input | 2 | Timer source clock code |
| tmr_load | input | 8 | Loaded countdown value |
| irq_pull | output | 1 | 1 = drive the active-low interrupt pin low |

## Verification
A flag held in the wrong state appears in the readback byte one cycle after the strobe or write that should have changed it. When its enable is set, the same fault also appears on `irq_pull` in that same cycle. A wrong window length in the pulse counter shows up one reference tick early or late: the bench checks the line just before the last tick and just after it. A missing restart on a retrigger makes the window close about 100 ticks too soon, which the retrigger test catches at the first check after the second event.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int CSR_BITS = 5;
    localparam int B_TIE    = 0;
    localparam int B_AIE    = 1;
    localparam int B_TF     = 2;
    localparam int B_AF     = 3;
    localparam int B_MODE   = 4;

    typedef enum logic [1:0] {
        SRC_4096 = 2'd0,
        SRC_64   = 2'd1,
        SRC_1    = 2'd2,
        SRC_1_60 = 2'd3
    } tsrc_e;

    typedef struct packed {
        logic pulse_mode;
        logic af;
        logic tf;
        logic aie;
        logic tie;
    } csr_t;

    function automatic int window_ticks(
        input tsrc_e src,
        input logic  load_is_one,
        input int    fast_short,
        input int    fast_long,
        input int    mid_short,
        input int    slow
    );
        case (src)
            SRC_4096: return load_is_one ? fast_short : fast_long;
            SRC_64:   return load_is_one ? mid_short  : slow;
            default:  return slow;
        endcase
    endfunction

endpackage

// File: rtl/irqc_csr.sv
module irqc_csr
    import irqc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [CSR_BITS-1:0] wr_bits,
    input  logic                alarm_hit,
    input  logic                timer_done,
    output csr_t                csr
);

    csr_t nxt;

    always_comb begin
        nxt = csr;
        if (wr_en) begin
            nxt.pulse_mode = wr_bits[B_MODE];
            nxt.aie        = wr_bits[B_AIE];
            nxt.tie        = wr_bits[B_TIE];
            nxt.af         = csr.af & wr_bits[B_AF];
            nxt.tf         = csr.tf & wr_bits[B_TF];
        end
        if (alarm_hit)  nxt.af = 1'b1;
        if (timer_done) nxt.tf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) csr <= '0;
        else     csr <= nxt;
    end

    // R3: a zero written to a flag bit clears it unless a new event arrives
    assert_af_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_bits[B_AF] && !alarm_hit) |=> !csr.af);
    assert_tf_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_bits[B_TF] && !timer_done) |=> !csr.tf);
    // R3: a write never raises a flag
    assert_no_set_by_write_R3: assert property (@(posedge clk) disable iff (rst)
        (!csr.af && !alarm_hit) |=> !csr.af);
    // R4: flags are sticky until a clearing write
    assert_af_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (csr.af && !(wr_en && !wr_bits[B_AF])) |=> csr.af);
    assert_tf_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (csr.tf && !(wr_en && !wr_bits[B_TF])) |=> csr.tf);
    assert_event_wins_R4: assert property (@(posedge clk) disable iff (rst)
        timer_done |=> csr.tf);

endmodule

// File: rtl/irqc_pulse.sv
module irqc_pulse
    import irqc_pkg::*;
#(
    parameter int LOAD_W     = 8,
    parameter int FAST_SHORT = 1,
    parameter int FAST_LONG  = 2,
    parameter int MID_SHORT  = 64,
    parameter int SLOW       = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              tick,
    input  tsrc_e             src,
    input  logic [LOAD_W-1:0] load,
    output logic              active
);

    localparam int MAXW  = (SLOW > FAST_LONG) ? SLOW : FAST_LONG;
    localparam int CNT_W = $clog2(MAXW + 1);

    logic [CNT_W-1:0] remain;
    logic             load_is_one;
    int               width;

    assign load_is_one = (load == LOAD_W'(1));
    assign width = window_ticks(src, load_is_one, FAST_SHORT, FAST_LONG, MID_SHORT, SLOW);

    always_ff @(posedge clk) begin
        if (rst)                         remain <= '0;
        else if (start)                  remain <= CNT_W'(width);
        else if (tick && remain != '0)   remain <= remain - 1'b1;
    end

    assign active = (remain != '0);

    // R8: a window opens on the edge that takes the event
    assert_open_on_event_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> active);
    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
        (!start && !active) |=> !active);
    // R9: the count never exceeds the longest window
    assert_bound_R9: assert property (@(posedge clk) disable iff (rst)
        remain <= CNT_W'(MAXW));
    // R10: the count only holds or falls without a new event
    assert_monotone_R10: assert property (@(posedge clk) disable iff (rst)
        !start |=> remain <= $past(remain));

endmodule

// File: rtl/irqc_merge.sv
module irqc_merge
    import irqc_pkg::*;
(
    input  csr_t csr,
    input  logic pulse_active,
    output logic pull
);

    logic alarm_part;
    logic timer_src;
    logic timer_part;

    always_comb begin
        alarm_part = csr.af & csr.aie;
        timer_src  = csr.pulse_mode ? pulse_active : csr.tf;
        timer_part = timer_src & csr.tie;
        pull       = alarm_part | timer_part;
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int LOAD_W     = 8,
    parameter int FAST_SHORT = 1,
    parameter int FAST_LONG  = 2,
    parameter int MID_SHORT  = 64,
    parameter int SLOW       = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              alarm_hit,
    input  logic              timer_done,
    input  logic              tick_8k,
    input  logic [1:0]        tmr_src,
    input  logic [LOAD_W-1:0] tmr_load,
    output logic              irq_pull
);

    csr_t csr;
    logic pulse_active;

    irqc_csr u_csr (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_bits    (wr_data[CSR_BITS-1:0]),
        .alarm_hit  (alarm_hit),
        .timer_done (timer_done),
        .csr        (csr)
    );

    irqc_pulse #(
        .LOAD_W     (LOAD_W),
        .FAST_SHORT (FAST_SHORT),
        .FAST_LONG  (FAST_LONG),
        .MID_SHORT  (MID_SHORT),
        .SLOW       (SLOW)
    ) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .start  (timer_done),
        .tick   (tick_8k),
        .src    (tsrc_e'(tmr_src)),
        .load   (tmr_load),
        .active (pulse_active)
    );

    irqc_merge u_merge (
        .csr          (csr),
        .pulse_active (pulse_active),
        .pull         (irq_pull)
    );

    assign rd_data = {{(DATA_W-CSR_BITS){1'b0}}, csr};

    // R5: both enables off keeps the line released
    assert_released_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_data[B_AIE] == 1'b0 && rd_data[B_TIE] == 1'b0) |-> !irq_pull);
    // R6: an enabled alarm flag holds the line low
    assert_alarm_level_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_data[B_AF] && rd_data[B_AIE]) |-> irq_pull);
    // R8: in pulse style the line rises together with the timer flag
    assert_pulse_with_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (timer_done && !wr_en && rd_data[B_MODE] && rd_data[B_TIE]) |=> (irq_pull && rd_data[B_TF]));
    // R2: unused bits read zero
    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (rst)
        rd_data[DATA_W-1:CSR_BITS] == '0);

endmodule

// File: tb/irqc_top_test.sv
module irqc_top_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       alarm_hit = 1'b0;
    logic       timer_done = 1'b0;
    logic       tick_8k = 1'b0;
    logic [1:0] tmr_src = '0;
    logic [7:0] tmr_load = 8'd1;
    logic       irq_pull;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irqc_top uut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .alarm_hit  (alarm_hit),
        .timer_done (timer_done),
        .tick_8k    (tick_8k),
        .tmr_src    (tmr_src),
        .tmr_load   (tmr_load),
        .irq_pull   (irq_pull)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic hit_alarm();
        alarm_hit = 1'b1;
        @(negedge clk);
        alarm_hit = 1'b0;
    endtask

    task automatic hit_timer();
        timer_done = 1'b1;
        @(negedge clk);
        timer_done = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_8k = 1'b1;
            @(negedge clk);
            tick_8k = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1 readback", rd_data, 8'h00);
        chk("R1 irq", irq_pull, 1'b0);
    endtask

    task automatic t_layout();
        wr(8'hFF);
        chk("R2 control bits load, flags stay 0, upper bits 0", rd_data, 8'h13);
        wr(8'h00);
        chk("R2 control bits clear", rd_data, 8'h00);
    endtask

    task automatic t_flag_write();
        wr(8'h00);
        hit_alarm();
        hit_timer();
        chk("R4 both flags set", rd_data, 8'h0C);
        ticks(3);
        chk("R4 flags sticky", rd_data, 8'h0C);
        wr(8'h08);
        chk("R3 clear TF keep AF", rd_data, 8'h08);
        wr(8'h0C);
        chk("R3 writing 1 does not set TF", rd_data, 8'h08);
        wr(8'h04);
        chk("R3 clear AF", rd_data, 8'h00);
    endtask

    task automatic t_collision();
        wr(8'h00);
        wr_en = 1'b1; wr_data = 8'h00; alarm_hit = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; alarm_hit = 1'b0;
        chk("R4 event beats clearing write", rd_data[3], 1'b1);
        wr(8'h00);
    endtask

    task automatic t_enables_off();
        wr(8'h10);
        hit_alarm();
        hit_timer();
        chk("R5 flags set", rd_data, 8'h1C);
        chk("R5 irq released", irq_pull, 1'b0);
        wr(8'h00);
    endtask

    task automatic t_alarm_level();
        wr(8'h12);
        hit_alarm();
        chk("R6 alarm pulls low", irq_pull, 1'b1);
        ticks(200);
        chk("R6 alarm held in pulse style", irq_pull, 1'b1);
        wr(8'h12 & 8'hF7);
        chk("R6 released after clear", irq_pull, 1'b0);
    endtask

    task automatic t_level();
        wr(8'h01);
        chk("R7 idle", irq_pull, 1'b0);
        hit_timer();
        chk("R7 level follows TF", irq_pull, 1'b1);
        ticks(140);
        chk("R7 level held", irq_pull, 1'b1);
        wr(8'h01);
        chk("R7 cleared with TF", irq_pull, 1'b0);
    endtask

    task automatic t_width(input logic [1:0] src, input logic [7:0] ld, input int n);
        wr(8'h11);
        tmr_src = src; tmr_load = ld;
        hit_timer();
        chk("R8 pulse starts with TF", {irq_pull, rd_data[2]}, 2'b11);
        if (n > 1) begin
            ticks(n - 1);
            chk("R9 pulse still open before last tick", irq_pull, 1'b1);
        end
        ticks(1);
        chk("R9 pulse closed after width", irq_pull, 1'b0);
        chk("R8 TF remains after pulse", rd_data[2], 1'b1);
    endtask

    task automatic t_retrigger();
        wr(8'h11);
        tmr_src = 2'd1; tmr_load = 8'd2;
        hit_timer();
        ticks(100);
        hit_timer();
        ticks(127);
        chk("R10 restarted window still open", irq_pull, 1'b1);
        ticks(1);
        chk("R10 restarted window closes", irq_pull, 1'b0);
    endtask

    task automatic t_tie_off();
        wr(8'h10);
        tmr_src = 2'd2;
        hit_timer();
        chk("R11 no pulse without enable", irq_pull, 1'b0);
        chk("R11 TF still set", rd_data[2], 1'b1);
        ticks(2);
        chk("R11 still released", irq_pull, 1'b0);
        wr(8'h00);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_layout();
        t_flag_write();
        t_collision();
        t_enables_off();
        t_alarm_level();
        t_level();
        t_width(2'd0, 8'd1, 1);
        t_width(2'd0, 8'd5, 2);
        t_width(2'd1, 8'd1, 64);
        t_width(2'd1, 8'd200, 128);
        t_width(2'd2, 8'd1, 128);
        t_width(2'd3, 8'd9, 128);
        t_retrigger();
        t_tie_off();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule